// File: doc/BRIEF.md
# SPI Transfer Burst Planner

This block splits a transfer of 64-bit words into a series of SPI bursts. Each SPI burst is then moved by one or more DMA bursts of equal size. The block takes the total word count with a single-cycle load strobe and keeps the count still to be planned in a register. For every SPI burst it presents one plan: the number of words in the burst, the DMA burst length, and the number of DMA bursts. The consumer takes a plan with the `nxt` strobe. The planned length is then subtracted from the remainder, and the block either computes the next plan or raises `done`.

Each plan length is chosen so that every DMA burst in it has the same size. Small remainders go out whole in one piece. Very large remainders are capped at the largest SPI burst the DMA burst counter allows. Other remainders are searched for the largest divisor between 8 and 2, testing one divisor per cycle. When no divisor fits, the remainder is cut back to a multiple of 8, and the cut is arranged so that a single word is never left for last.

Top module: `burst_planner`

## Requirements
- R1: A load with a total of 0 or 1 sets `reject` on the next cycle, and no plan or `done` follows. The next load clears `reject`.
- R2: When the remainder is at most FIFO_DEPTH (default 16), the plan takes the whole remainder. The DMA burst length equals the remainder and the DMA burst count is 1.
- R3: When the remainder is at least MAX = 8 × 65535 = 524280 and is not exactly MAX + 1, the plan is MAX words with a DMA burst length of 8 and a count of 65535.
- R4: When the remainder is exactly MAX + 1, the plan is MAX − 8 words with a DMA burst length of 8 and a count of 65534. This leaves 9 words for the next plan.
- R5: In all other cases, the DMA burst length is the largest d from 8 down to 2 that divides the remainder exactly. The plan takes the whole remainder and the count is remainder / d.
- R6: When no d from 2 to 8 divides the remainder, the plan length is the remainder minus (remainder mod 8), minus a further 8 if that modulus is 1. The DMA burst length is 8 and the count is length / 8.
- R7: `plan_valid` rises no more than 7 cycles after a load or an accepted plan. While it is high and `nxt` is low, the plan fields do not change.
- R8: `nxt` with `plan_valid` high subtracts the plan length from the remainder and drops `plan_valid`. When the remainder reaches zero, `done` is set. `nxt` has no effect when `plan_valid` is low.
- R9: After reset, `plan_valid`, `done` and `reject` are all low.
- R10: No plan ever has a length of 1, and the plan lengths of a transfer add up to its total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a new transfer with `total` |
| total | input | CNT_W | Total number of 64-bit words |
| nxt | input | 1 | Accept the current plan |
| plan_valid | output | 1 | Plan fields are valid |
| plan_len | output | CNT_W | Words in this SPI burst |
| plan_dlen | output | DLEN_W | DMA burst length in words |
| plan_dcnt | output | CNT_W | Number of DMA bursts |
| done | output | 1 | The whole transfer has been planned |
| reject | output | 1 | The last load was too short to plan |

## Verification
The hardest behaviour to reach from the ports is the pair of cases next to the maximum burst. Reaching them needs totals above half a million words, with remainders that land exactly on MAX + 1 or on MAX − 1. The stimulus table loads those totals directly, and it also includes totals with no divisor at all, whose mod-8 remainder is 1, 3 or 7. Those totals force the full seven-step search and the extra 8-word cut-back, and the bench then follows the leftover tail through its second plan.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_READY, ST_DONE} bp_state_t;
  typedef enum logic [1:0] {K_SMALL, K_NEAR, K_BIG, K_SEARCH} bp_kind_t;

  function automatic int dlen_max(input int fifo_depth, input int dlen_def);
    return (fifo_depth > dlen_def) ? fifo_depth : dlen_def;
  endfunction
endpackage

// File: rtl/bp_div_bank.sv
module bp_div_bank #(
  parameter int CNT_W    = 32,
  parameter int DLEN_DEF = 8
) (
  input  logic [CNT_W-1:0] remain,
  output logic [DLEN_DEF:0] div_ok,
  output logic [CNT_W-1:0] quot [DLEN_DEF+1]
);
  assign div_ok[0] = 1'b0;
  assign div_ok[1] = 1'b0;
  assign quot[0]   = '0;
  assign quot[1]   = '0;

  for (genvar d = 2; d <= DLEN_DEF; d++) begin : g_div
    assign div_ok[d] = ((remain % CNT_W'(d)) == '0);
    assign quot[d]   = remain / CNT_W'(d);
  end
endmodule

// File: rtl/bp_case_sel.sv
module bp_case_sel
  import bp_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int DLEN_DEF   = 8,
  parameter int BCNT_MAX   = 65535,
  parameter int DLEN_W     = 5
) (
  input  logic [CNT_W-1:0]  remain,
  output bp_kind_t          kind,
  output logic [CNT_W-1:0]  fast_len,
  output logic [DLEN_W-1:0] fast_dlen,
  output logic [CNT_W-1:0]  fast_dcnt,
  output logic [CNT_W-1:0]  fb_len,
  output logic [CNT_W-1:0]  fb_dcnt
);
  localparam logic [CNT_W-1:0] MAX_BURST = CNT_W'(DLEN_DEF * BCNT_MAX);
  localparam logic [CNT_W-1:0] DEF_W     = CNT_W'(DLEN_DEF);

  logic [CNT_W-1:0] rem_def;

  always_comb begin
    kind      = K_SEARCH;
    fast_len  = remain;
    fast_dlen = remain[DLEN_W-1:0];
    fast_dcnt = CNT_W'(1);
    if (remain <= CNT_W'(FIFO_DEPTH)) begin
      kind = K_SMALL;
    end else if (remain == MAX_BURST + CNT_W'(1)) begin
      kind      = K_NEAR;
      fast_len  = MAX_BURST - DEF_W;
      fast_dlen = DLEN_W'(DLEN_DEF);
      fast_dcnt = CNT_W'(BCNT_MAX - 1);
    end else if (remain >= MAX_BURST) begin
      kind      = K_BIG;
      fast_len  = MAX_BURST;
      fast_dlen = DLEN_W'(DLEN_DEF);
      fast_dcnt = CNT_W'(BCNT_MAX);
    end
  end

  always_comb begin
    rem_def = remain % DEF_W;
    fb_len  = remain - rem_def - ((rem_def == CNT_W'(1)) ? DEF_W : '0);
    fb_dcnt = fb_len / DEF_W;
  end
endmodule

// File: rtl/burst_planner.sv
module burst_planner
  import bp_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int DLEN_DEF   = 8,
  parameter int BCNT_MAX   = 65535,
  parameter int DLEN_W     = $clog2(dlen_max(FIFO_DEPTH, DLEN_DEF) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  total,
  input  logic              nxt,
  output logic              plan_valid,
  output logic [CNT_W-1:0]  plan_len,
  output logic [DLEN_W-1:0] plan_dlen,
  output logic [CNT_W-1:0]  plan_dcnt,
  output logic              done,
  output logic              reject
);
  localparam int DIX_W = $clog2(DLEN_DEF + 1);

  bp_state_t        state;
  logic [CNT_W-1:0] remain;
  logic [DIX_W-1:0] div;

  bp_kind_t          kind;
  logic [CNT_W-1:0]  fast_len, fast_dcnt, fb_len, fb_dcnt;
  logic [DLEN_W-1:0] fast_dlen;
  logic [DLEN_DEF:0] div_ok;
  logic [CNT_W-1:0]  quot [DLEN_DEF+1];

  bp_case_sel #(
    .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .DLEN_DEF(DLEN_DEF),
    .BCNT_MAX(BCNT_MAX), .DLEN_W(DLEN_W)
  ) u_sel (
    .remain(remain), .kind(kind), .fast_len(fast_len), .fast_dlen(fast_dlen),
    .fast_dcnt(fast_dcnt), .fb_len(fb_len), .fb_dcnt(fb_dcnt)
  );

  bp_div_bank #(.CNT_W(CNT_W), .DLEN_DEF(DLEN_DEF)) u_div (
    .remain(remain), .div_ok(div_ok), .quot(quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      remain     <= '0;
      div        <= DIX_W'(DLEN_DEF);
      plan_valid <= 1'b0;
      plan_len   <= '0;
      plan_dlen  <= '0;
      plan_dcnt  <= '0;
      done       <= 1'b0;
      reject     <= 1'b0;
    end else if (load) begin
      reject     <= (total < CNT_W'(2));
      done       <= 1'b0;
      plan_valid <= 1'b0;
      remain     <= total;
      div        <= DIX_W'(DLEN_DEF);
      state      <= (total < CNT_W'(2)) ? ST_IDLE : ST_CALC;
    end else begin
      case (state)
        ST_CALC: begin
          if (kind != K_SEARCH) begin
            plan_len   <= fast_len;
            plan_dlen  <= fast_dlen;
            plan_dcnt  <= fast_dcnt;
            plan_valid <= 1'b1;
            state      <= ST_READY;
          end else if (div_ok[div]) begin
            plan_len   <= remain;
            plan_dlen  <= DLEN_W'(div);
            plan_dcnt  <= quot[div];
            plan_valid <= 1'b1;
            state      <= ST_READY;
          end else if (div == DIX_W'(2)) begin
            plan_len   <= fb_len;
            plan_dlen  <= DLEN_W'(DLEN_DEF);
            plan_dcnt  <= fb_dcnt;
            plan_valid <= 1'b1;
            state      <= ST_READY;
          end else begin
            div <= div - DIX_W'(1);
          end
        end
        ST_READY: begin
          if (nxt) begin
            plan_valid <= 1'b0;
            remain     <= remain - plan_len;
            div        <= DIX_W'(DLEN_DEF);
            if (remain == plan_len) begin
              done  <= 1'b1;
              state <= ST_DONE;
            end else begin
              state <= ST_CALC;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int DLEN_DEF   = 8,
  parameter int BCNT_MAX   = 65535,
  parameter int DLEN_W     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              nxt,
  input logic              plan_valid,
  input logic [CNT_W-1:0]  plan_len,
  input logic [DLEN_W-1:0] plan_dlen,
  input logic [CNT_W-1:0]  plan_dcnt,
  input logic              done,
  input logic              reject
);
  localparam longint MAXB = longint'(DLEN_DEF) * longint'(BCNT_MAX);

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    reject |-> (!plan_valid && !done));

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (rst)
    plan_valid |-> (longint'(plan_len) <= MAXB));

  assert_exact_split_R5: assert property (@(posedge clk) disable iff (rst)
    (plan_valid && plan_len > CNT_W'(FIFO_DEPTH)) |->
      (64'(plan_dcnt) * 64'(plan_dlen) == 64'(plan_len)));

  assert_dlen_range_R6: assert property (@(posedge clk) disable iff (rst)
    (plan_valid && plan_len > CNT_W'(FIFO_DEPTH)) |->
      (plan_dlen >= DLEN_W'(2) && plan_dlen <= DLEN_W'(DLEN_DEF)));

  assert_hold_plan_R7: assert property (@(posedge clk) disable iff (rst)
    (plan_valid && !nxt && !load) |=>
      (plan_valid && $stable(plan_len) && $stable(plan_dlen) && $stable(plan_dcnt)));

  assert_accept_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (plan_valid && nxt && !load) |=> !plan_valid);

  assert_valid_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(plan_valid && done));

  assert_no_single_R10: assert property (@(posedge clk) disable iff (rst)
    plan_valid |-> (plan_len >= CNT_W'(2)));
endmodule

bind burst_planner bp_checker #(
  .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .DLEN_DEF(DLEN_DEF),
  .BCNT_MAX(BCNT_MAX), .DLEN_W(DLEN_W)
) u_chk (
  .clk(clk), .rst(rst), .load(load), .nxt(nxt), .plan_valid(plan_valid),
  .plan_len(plan_len), .plan_dlen(plan_dlen), .plan_dcnt(plan_dcnt),
  .done(done), .reject(reject)
);

// File: tb/sim_burst_planner.sv
`timescale 1ns/1ps
module sim_burst_planner;
  localparam int CNT_W  = 32;
  localparam int DLEN_W = 5;
  localparam int N      = 17;

  // Columns: total, plans, len0, dlen0, cnt0, len1, dlen1, cnt1
  // rows 0-2 R2, 3-8 R5, 9-12 R6, 13 and 15 R3, 14 R4, 16 R5 with a wide count
  localparam int TOT [N] = '{10, 2, 16, 24, 21, 18, 25, 22, 27, 17, 19, 23, 41,
                             524280, 524281, 524285, 524279};
  localparam int NP  [N] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 1, 2, 2, 1};
  localparam int L0  [N] = '{10, 2, 16, 24, 21, 18, 25, 22, 27, 8, 16, 16, 32,
                             524280, 524272, 524280, 524279};
  localparam int D0  [N] = '{10, 2, 16, 8, 7, 6, 5, 2, 3, 8, 8, 8, 8, 8, 8, 8, 7};
  localparam int C0  [N] = '{1, 1, 1, 3, 3, 3, 5, 11, 9, 1, 2, 2, 4,
                             65535, 65534, 65535, 74897};
  localparam int L1  [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 9, 3, 7, 9, 0, 9, 5, 0};
  localparam int D1  [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 9, 3, 7, 9, 0, 9, 5, 0};
  localparam int C1  [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic nxt = 1'b0;
  logic [CNT_W-1:0] total = '0;
  logic plan_valid, done, reject;
  logic [CNT_W-1:0] plan_len, plan_dcnt;
  logic [DLEN_W-1:0] plan_dlen;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  burst_planner u0 (
    .clk(clk), .rst(rst), .load(load), .total(total), .nxt(nxt),
    .plan_valid(plan_valid), .plan_len(plan_len), .plan_dlen(plan_dlen),
    .plan_dcnt(plan_dcnt), .done(done), .reject(reject)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int t);
    @(negedge clk);
    load  = 1'b1;
    total = CNT_W'(t);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic take_plan(input int el, input int ed, input int ec, inout longint sum);
    int lat = 0;
    while (!plan_valid && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    chk(plan_valid && lat <= 7, "R7 latency", lat, 7);
    chk(plan_len == CNT_W'(el), "R2/R3/R4/R5/R6 len", plan_len, el);
    chk(plan_dlen == DLEN_W'(ed), "R5/R6 dlen", plan_dlen, ed);
    chk(plan_dcnt == CNT_W'(ec), "R5/R6 dcnt", plan_dcnt, ec);
    chk(plan_len != CNT_W'(1), "R10 no single", plan_len, 2);
    sum += longint'(plan_len);
    @(negedge clk);
    chk(plan_valid && plan_len == CNT_W'(el), "R7 hold", plan_len, el);
    nxt = 1'b1;
    @(negedge clk);
    nxt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    longint sum;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!plan_valid, "R9 valid", plan_valid, 0);
    chk(!done, "R9 done", done, 0);
    chk(!reject, "R9 reject", reject, 0);

    for (int i = 0; i < N; i++) begin
      sum = 0;
      start(TOT[i]);
      take_plan(L0[i], D0[i], C0[i], sum);
      if (NP[i] == 2) begin
        chk(!done, "R8 not done mid", done, 0);
        take_plan(L1[i], D1[i], C1[i], sum);
      end
      chk(done && !plan_valid, "R8 done", done, 1);
      chk(sum == longint'(TOT[i]), "R10 sum", sum, TOT[i]);
    end

    // R8: nxt after done has no effect
    nxt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    nxt = 1'b0;
    chk(done && !plan_valid, "R8 ignored nxt", plan_valid, 0);

    // R1: totals too short
    start(1);
    chk(reject && !done && !plan_valid, "R1 total=1", reject, 1);
    repeat (8) @(negedge clk);
    chk(!plan_valid && !done, "R1 quiet", plan_valid, 0);
    start(0);
    chk(reject, "R1 total=0", reject, 1);
    start(5);
    chk(!reject, "R1 cleared", reject, 0);
    sum = 0;
    take_plan(5, 5, 1, sum);
    chk(done, "R2 done after tail", done, 1);

    // R8: nxt before plan ready must not consume anything
    start(22);
    nxt = 1'b1;
    @(negedge clk);
    nxt = 1'b0;
    sum = 0;
    take_plan(22, 2, 11, sum);
    chk(done, "R8 early nxt ignored", done, 1);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule